// File: doc/BRIEF.md
# Debug Command Register Controller

This block stands in for the instruction register of a JTAG-style test access path and holds an 8-bit debug command. The TAP state machine, which is outside the block, marks its states on single-cycle level inputs. While the TAP is in the shift-IR state, a shift stage takes serial bits from `tdi`, least significant bit first, and drives its lowest bit on `tdo`. On update-IR the shift stage is copied into the command register. The command names a debug resource through its select field. It also carries a read/write flag and two control bits: one to step the CPU and one to leave debug mode.

Loading a command does not act on it. Every action the command encodes waits for the next update-DR: the access to a selected resource, the step, and the exit. This holds even when the command selects no resource at all. At that point the block gives out one-cycle strobes. A separate flag, `dbgAck`, tells the system that the CPU is held under debug control. The flag rises on the first debug-entry pulse. It stays high while the CPU steps one instruction at a time. It drops only when a command with both control bits set, selecting either no resource or the CPU scan control register, is carried out on update-DR.

Top module: `dbg_cmd_reg`

## Requirements
- R1: After `rstN` is released, `regSel` reads 5'h1F (no resource), `tdo`, `dbgAck` and all strobes read 0.
- R2: In a shift-IR cycle, `tdo` carries bit 0 of the shift stage, and `tdo` is 0 outside shift-IR. Capture-IR loads the stage with 8'h01. Each shift moves `tdi` into bit 7 and drops bit 0, so a loaded byte comes out on `tdo` LSB first after eight further shifts.
- R3: Update-IR copies the shift stage into the command register. `regSel` shows command bits [4:0] from the following cycle. Capture and shift without update-IR leave `regSel` unchanged.
- R4: On update-DR with a select other than 5'h1F, `accessStrobe` pulses for one cycle. `accessWrite` pulses with it when command bit 7 (read/write) is 1.
- R5: `goStrobe` and `exitStrobe` pulse for one cycle after update-DR and copy command bit 6 (step) and bit 5 (exit). These strobes fire even when the select is 5'h1F, and update-IR alone never produces a strobe.
- R6: A `dbgEntry` pulse sets `dbgAck` from the next cycle.
- R7: `dbgAck` clears after update-DR only when the command has bits 6 and 5 both set and a select of 5'h1F or 5'h00. A step-only command, an exit-only command, or both bits with any other select leaves it set.
- R8: `dbgAck` stays set across repeated step commands and repeated `dbgEntry` pulses.
- R9: `tapReset` forces the command register to select 5'h1F with bits 7..5 cleared, and a later update-DR then gives no strobe.
- R10: When `dbgEntry` and a releasing update-DR occur in the same cycle, `dbgAck` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| captureIr | input | 1 | TAP is in capture-IR |
| shiftIr | input | 1 | TAP is in shift-IR |
| updateIr | input | 1 | TAP is in update-IR |
| updateDr | input | 1 | TAP is in update-DR |
| tapReset | input | 1 | TAP is in test-logic-reset |
| dbgEntry | input | 1 | CPU entered debug state (pulse) |
| tdo | output | 1 | Serial data out |
| regSel | output | 5 | Decoded resource select |
| accessStrobe | output | 1 | Resource access pulse |
| accessWrite | output | 1 | Access is a write |
| goStrobe | output | 1 | Single-step pulse |
| exitStrobe | output | 1 | Exit-debug pulse |
| dbgAck | output | 1 | CPU held under debug control |

## Verification
The bench loads command words that cover several cases:
- step only, exit only, and both bits with a select of 5'h00, 5'h1F and an ordinary value;
- a write access;
- a command loaded and then erased by `tapReset`.

Each word is followed by an update-DR. A scoreboard matches every strobe pulse against the bits of the loaded word. This separates a strobe that copies the wrong bit from one that fires at update-IR instead of update-DR.

Two sequences probe `dbgAck` beyond the basic cases:
- repeated entry pulses mixed with steps;
- an entry pulse that coincides with a releasing command.

These tell a release that checks only the control bits apart from one that also checks the select, and show which of entry and release takes priority. A shift-through pass with no update-IR checks the capture pattern, the serial order, and that the command register stays unchanged.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int CMD_W = 8;
  localparam int SEL_W = 5;
  localparam logic [SEL_W-1:0] SEL_NONE = '1;
  localparam logic [SEL_W-1:0] SEL_CPUSCR = '0;
  localparam logic [CMD_W-1:0] CAPTURE_PAT = 8'h01;

  // Command word: order of fields fixes bit 7 rw, 6 go, 5 ex, 4..0 select
  typedef struct packed {
    logic rw;
    logic go;
    logic ex;
    logic [SEL_W-1:0] sel;
  } cmdT;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic shift;
    logic load;
    logic clear;
  } dpCtlT;

  localparam cmdT CMD_IDLE = '{rw: 1'b0, go: 1'b0, ex: 1'b0, sel: SEL_NONE};
endpackage

// File: rtl/dcr_datapath.sv
module dcr_datapath
  import dcr_pkg::*;
(
  input  logic tck,
  input  logic rstN,
  input  logic tdi,
  input  dpCtlT ctl,
  output logic tdo,
  output cmdT  cmd
);
  logic [CMD_W-1:0] shiftStage;

  // Serial stage: capture a fixed pattern, shift LSB first
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)            shiftStage <= '0;
    else if (ctl.capture) shiftStage <= CAPTURE_PAT;
    else if (ctl.shift)   shiftStage <= {tdi, shiftStage[CMD_W-1:1]};
  end

  // Parallel command register
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)          cmd <= CMD_IDLE;
    else if (ctl.clear) cmd <= CMD_IDLE;
    else if (ctl.load)  cmd <= cmdT'(shiftStage);
  end

  assign tdo = ctl.shift & shiftStage[0];
endmodule

// File: rtl/dcr_control.sv
module dcr_control
  import dcr_pkg::*;
(
  input  logic  tck,
  input  logic  rstN,
  input  logic  captureIr,
  input  logic  shiftIr,
  input  logic  updateIr,
  input  logic  updateDr,
  input  logic  tapReset,
  input  logic  dbgEntry,
  input  cmdT   cmd,
  output dpCtlT ctl,
  output logic  accessStrobe,
  output logic  accessWrite,
  output logic  goStrobe,
  output logic  exitStrobe,
  output logic  dbgAck
);
  logic drFire;
  logic selHit;
  logic releaseCpu;

  always_comb begin
    ctl.capture = captureIr & ~tapReset;
    ctl.shift   = shiftIr   & ~tapReset;
    ctl.load    = updateIr  & ~tapReset;
    ctl.clear   = tapReset;
  end

  assign drFire     = updateDr & ~tapReset;
  assign selHit     = (cmd.sel != SEL_NONE);
  assign releaseCpu = drFire & cmd.go & cmd.ex &
                      ((cmd.sel == SEL_NONE) | (cmd.sel == SEL_CPUSCR));

  // One-cycle action strobes, deferred to update-DR
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      accessStrobe <= 1'b0;
      accessWrite  <= 1'b0;
      goStrobe     <= 1'b0;
      exitStrobe   <= 1'b0;
    end else begin
      accessStrobe <= drFire & selHit;
      accessWrite  <= drFire & selHit & cmd.rw;
      goStrobe     <= drFire & cmd.go;
      exitStrobe   <= drFire & cmd.ex;
    end
  end

  // Acknowledge: entry sets (and wins), release clears
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           dbgAck <= 1'b0;
    else if (dbgEntry)   dbgAck <= 1'b1;
    else if (releaseCpu) dbgAck <= 1'b0;
  end
endmodule

// File: rtl/dbg_cmd_reg.sv
module dbg_cmd_reg
  import dcr_pkg::*;
(
  input  logic             tck,
  input  logic             rstN,
  input  logic             tdi,
  input  logic             captureIr,
  input  logic             shiftIr,
  input  logic             updateIr,
  input  logic             updateDr,
  input  logic             tapReset,
  input  logic             dbgEntry,
  output logic             tdo,
  output logic [SEL_W-1:0] regSel,
  output logic             accessStrobe,
  output logic             accessWrite,
  output logic             goStrobe,
  output logic             exitStrobe,
  output logic             dbgAck
);
  dpCtlT ctl;
  cmdT   cmd;

  dcr_control i_control (
    .tck(tck), .rstN(rstN),
    .captureIr(captureIr), .shiftIr(shiftIr), .updateIr(updateIr),
    .updateDr(updateDr), .tapReset(tapReset), .dbgEntry(dbgEntry),
    .cmd(cmd), .ctl(ctl),
    .accessStrobe(accessStrobe), .accessWrite(accessWrite),
    .goStrobe(goStrobe), .exitStrobe(exitStrobe), .dbgAck(dbgAck)
  );

  dcr_datapath i_datapath (
    .tck(tck), .rstN(rstN), .tdi(tdi), .ctl(ctl), .tdo(tdo), .cmd(cmd)
  );

  assign regSel = cmd.sel;
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker
  import dcr_pkg::*;
(
  input logic             tck,
  input logic             rstN,
  input logic             updateIr,
  input logic             updateDr,
  input logic             tapReset,
  input logic             dbgEntry,
  input logic [SEL_W-1:0] regSel,
  input logic             accessStrobe,
  input logic             accessWrite,
  input logic             goStrobe,
  input logic             exitStrobe,
  input logic             dbgAck
);
  p_sel_hold_r3: assert property (@(posedge tck) disable iff (!rstN)
    (!updateIr && !tapReset) |=> $stable(regSel));

  p_write_with_access_r4: assert property (@(posedge tck) disable iff (!rstN)
    accessWrite |-> accessStrobe);

  p_strobe_after_dr_r5: assert property (@(posedge tck) disable iff (!rstN)
    (goStrobe || exitStrobe || accessStrobe) |-> ($past(updateDr) && !$past(tapReset)));

  p_ack_rise_r6: assert property (@(posedge tck) disable iff (!rstN)
    $rose(dbgAck) |-> $past(dbgEntry));

  p_ack_fall_r7: assert property (@(posedge tck) disable iff (!rstN)
    $fell(dbgAck) |-> (goStrobe && exitStrobe));

  p_ack_hold_r8: assert property (@(posedge tck) disable iff (!rstN)
    (dbgAck && !updateDr) |=> dbgAck);

  p_tap_reset_r9: assert property (@(posedge tck) disable iff (!rstN)
    tapReset |=> (regSel == SEL_NONE));
endmodule

bind dbg_cmd_reg dcr_checker i_checker (
  .tck(tck), .rstN(rstN), .updateIr(updateIr), .updateDr(updateDr),
  .tapReset(tapReset), .dbgEntry(dbgEntry), .regSel(regSel),
  .accessStrobe(accessStrobe), .accessWrite(accessWrite),
  .goStrobe(goStrobe), .exitStrobe(exitStrobe), .dbgAck(dbgAck)
);

// File: tb/test_dbg_cmd_reg.sv
module test_dbg_cmd_reg;
  logic tck = 1'b0;
  logic rstN, tdi, captureIr, shiftIr, updateIr, updateDr, tapReset, dbgEntry;
  logic tdo, accessStrobe, accessWrite, goStrobe, exitStrobe, dbgAck;
  logic [4:0] regSel;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct packed {
    logic acc;
    logic wr;
    logic go;
    logic ex;
  } expT;
  expT expQ[$];

  logic [7:0] modelCmd;
  logic       modelAck;

  always #2 tck = ~tck;

  dbg_cmd_reg i_dbg_cmd_reg (
    .tck(tck), .rstN(rstN), .tdi(tdi), .captureIr(captureIr), .shiftIr(shiftIr),
    .updateIr(updateIr), .updateDr(updateDr), .tapReset(tapReset), .dbgEntry(dbgEntry),
    .tdo(tdo), .regSel(regSel), .accessStrobe(accessStrobe), .accessWrite(accessWrite),
    .goStrobe(goStrobe), .exitStrobe(exitStrobe), .dbgAck(dbgAck)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Monitor: compares every strobe pulse against the scoreboard queue
  always @(posedge tck) begin
    #1;
    if (rstN) begin
      if (accessStrobe || accessWrite || goStrobe || exitStrobe) begin
        if (expQ.size() == 0) begin
          check(0, "R5 unexpected strobe", {accessStrobe, accessWrite, goStrobe, exitStrobe}, 0);
        end else begin
          expT e;
          e = expQ.pop_front();
          check({accessStrobe, accessWrite, goStrobe, exitStrobe} == e, "R4/R5 strobe set",
                {accessStrobe, accessWrite, goStrobe, exitStrobe}, e);
        end
      end else if (expQ.size() != 0) begin
        expT e;
        e = expQ.pop_front();
        check(0, "R5 missing strobe", 0, e);
      end
    end
  end

  // Capture, shift 8 bits, optionally update-IR
  task automatic loadCmd(input logic [7:0] c, input bit doUpdate);
    logic [4:0] selBefore;
    selBefore = regSel;
    captureIr = 1;
    @(negedge tck); captureIr = 0; shiftIr = 1;
    for (int i = 0; i < 8; i++) begin
      tdi = c[i];
      #1 check(tdo == (i == 0), "R2 capture pattern on tdo", tdo, (i == 0));
      @(negedge tck);
    end
    shiftIr = 0;
    #1 check(tdo == 1'b0, "R2 tdo idle outside shift", tdo, 0);
    if (doUpdate) begin
      updateIr = 1;
      @(negedge tck); updateIr = 0;
      modelCmd = c;
      #1 check(regSel == c[4:0], "R3 select after update-IR", regSel, c[4:0]);
      check(!goStrobe && !exitStrobe && !accessStrobe, "R5 no strobe on update-IR",
            {goStrobe, exitStrobe, accessStrobe}, 0);
    end else begin
      #1 check(regSel == selBefore, "R3 select held without update-IR", regSel, selBefore);
    end
  endtask

  // Shift a byte in then shift it out, no update
  task automatic shiftThrough(input logic [7:0] c);
    captureIr = 1;
    @(negedge tck); captureIr = 0; shiftIr = 1;
    for (int i = 0; i < 8; i++) begin
      tdi = c[i];
      @(negedge tck);
    end
    for (int k = 0; k < 8; k++) begin
      tdi = 0;
      #1 check(tdo == c[k], "R2 serial order on tdo", tdo, c[k]);
      @(negedge tck);
    end
    shiftIr = 0;
  endtask

  // Update-DR with optional simultaneous entry pulse
  task automatic runDr(input bit withEntry);
    expT e;
    bit rel;
    e.acc = (modelCmd[4:0] != 5'h1F);
    e.wr  = e.acc & modelCmd[7];
    e.go  = modelCmd[6];
    e.ex  = modelCmd[5];
    if (e != '0) expQ.push_back(e);
    rel = modelCmd[6] & modelCmd[5] & ((modelCmd[4:0] == 5'h1F) || (modelCmd[4:0] == 5'h00));
    updateDr = 1;
    dbgEntry = withEntry;
    @(negedge tck); updateDr = 0; dbgEntry = 0;
    if (withEntry) modelAck = 1;
    else if (rel)  modelAck = 0;
    #1 check(dbgAck == modelAck, withEntry ? "R10 entry wins over release" : "R7/R8 ack after update-DR",
             dbgAck, modelAck);
  endtask

  task automatic enterDebug();
    dbgEntry = 1;
    @(negedge tck); dbgEntry = 0;
    modelAck = 1;
    #1 check(dbgAck == 1'b1, "R6 ack set on entry", dbgAck, 1);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rstN = 0; tdi = 0; captureIr = 0; shiftIr = 0; updateIr = 0; updateDr = 0;
    tapReset = 0; dbgEntry = 0;
    modelCmd = 8'h1F; modelAck = 0;
    repeat (3) @(negedge tck);
    rstN = 1;
    @(negedge tck);
    #1;
    // R1 reset state
    check(regSel == 5'h1F, "R1 reset select", regSel, 5'h1F);
    check(!dbgAck, "R1 reset ack", dbgAck, 0);
    check(!tdo, "R1 reset tdo", tdo, 0);
    check(!(goStrobe | exitStrobe | accessStrobe | accessWrite), "R1 reset strobes",
          {goStrobe, exitStrobe, accessStrobe, accessWrite}, 0);

    // R2 serial order, R3 hold without update
    shiftThrough(8'hA6);
    #1 check(regSel == 5'h1F, "R3 shift-through leaves select", regSel, 5'h1F);

    // R5 data-less go/exit with no resource, R7 release
    enterDebug();
    loadCmd(8'h45, 1);   // step, select 5
    runDr(0);            // R8 ack stays
    enterDebug();        // R8 repeated entry
    loadCmd(8'h45, 1);
    runDr(0);
    loadCmd(8'h3F, 1);   // exit only, no resource
    runDr(0);
    loadCmd(8'h63, 1);   // go+ex, ordinary select: ack stays (R7)
    runDr(0);
    loadCmd(8'h12, 0);   // R3 no update: select stays 3
    loadCmd(8'h85, 1);   // R4 write access to select 5
    runDr(0);
    loadCmd(8'h04, 1);   // R4 read access
    runDr(0);
    loadCmd(8'h60, 1);   // go+ex, CPU scan control: release (R7)
    runDr(0);
    enterDebug();
    loadCmd(8'h7F, 1);   // go+ex, no resource: release (R7)
    runDr(0);
    enterDebug();
    loadCmd(8'h60, 1);   // R10 simultaneous entry and release
    runDr(1);

    // R9 test-logic-reset clears command
    loadCmd(8'h6A, 1);
    tapReset = 1;
    @(negedge tck); tapReset = 0;
    modelCmd = 8'h1F;
    #1 check(regSel == 5'h1F, "R9 select after tap reset", regSel, 5'h1F);
    runDr(0);            // no strobe expected, ack stays set
    @(negedge tck);
    #1 check(!(goStrobe | exitStrobe | accessStrobe), "R9 no strobe after tap reset",
             {goStrobe, exitStrobe, accessStrobe}, 0);

    repeat (3) @(negedge tck);
    check(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    summary();
  end
endmodule